// File: doc/BRIEF.md
# Unsigned Long-by-Word Divider with Up-Front Overflow

This block divides an unsigned dividend of two words by an unsigned one-word divisor. The dividend arrives as a high word and a low word, and the divisor as a single word. The divider works in place on two result registers. The low-word register ends up holding the quotient. The high-word register ends up holding the remainder. An overflow flag reports whether the true quotient fits in one word.

The overflow decision is made before any iteration begins. It comes from one full-width unsigned comparison of the divisor against the high word. The divide overflows exactly when the divisor is less than or equal to the high word, and a zero divisor falls under that rule. Because the comparison covers the full width, it stays correct when both operands have their top bit set.

When the decision is overflow, the divider finishes at once. When it is not, the divider runs a restoring shift-and-subtract loop. The loop produces one quotient bit per clock. A host pulses `start_i` while the block is idle and waits for the one-cycle `done_o` pulse.

Top module: `udiv_core`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `ovf_o` are 0, and `hi_o` and `lo_o` are all zeros.
- R2: A start accepted while idle sets `ovf_o` to 1 exactly when the divisor, read as an unsigned number, is less than or equal to the high word. This covers a zero divisor and operands whose top bits are both set. Example: high F0F0h, low 0F0Fh, divisor F0F0h gives a flag of 1.
- R3: Without overflow, `lo_o` holds floor({hi,lo} / divisor) and `hi_o` holds {hi,lo} mod divisor. Both values are valid while `done_o` is 1.
- R4: With overflow, `lo_o` holds all ones and `hi_o` holds the unchanged high word of the dividend.
- R5: Without overflow, `busy_o` is 1 for exactly W clock cycles after the accepting edge. `done_o` rises on the same edge at which `busy_o` falls, which is W edges after the accepting edge.
- R6: With overflow, `busy_o` stays 0, and `done_o` is 1 in the cycle right after the accepting edge.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running divide keeps its operands, its result and its timing.
- R8: `done_o` lasts exactly one cycle and is never 1 while `busy_o` is 1.
- R9: After `done_o`, the results and the flag hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only while idle |
| hi_i | input | W | Dividend high word |
| lo_i | input | W | Dividend low word |
| dvsr_i | input | W | Divisor |
| busy_o | output | 1 | Iterative divide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | W | High-word register; holds the remainder at completion |
| lo_o | output | W | Low-word register; holds the quotient at completion |
| ovf_o | output | 1 | Quotient does not fit in W bits |

## Verification
The bench builds the block with the default W = 16. At that width the dividend has 32 bits, so a plain 32-bit division inside the bench serves as an exact reference. The directed cases reach the borders of the overflow decision: a divisor equal to the high word, a divisor one above it, and a zero divisor. They also cover every family in which both top bits are set, including the F0F0h example. Random operands fill in the ordinary quotient and remainder values. Restarts during a run and result hold after completion are driven directly at the ports.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

  typedef enum logic [0:0] {
    UD_IDLE = 1'b0,
    UD_RUN  = 1'b1
  } udiv_state_e;

endpackage

// File: rtl/udiv_ovf_detect.sv
module udiv_ovf_detect #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] dvsr_i,
  output logic         ovf_o
);

  // The quotient fits in W bits only when the divisor is strictly above the
  // high word. The compare is done at full unsigned width, so operands whose
  // top bits are both set take the same path as any others.
  function automatic logic quotient_too_wide(input logic [W-1:0] h,
                                             input logic [W-1:0] d);
    return (d <= h);
  endfunction

  assign ovf_o = quotient_too_wide(hi_i, dvsr_i);

endmodule

// File: rtl/udiv_step.sv
module udiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o,
  output logic         qbit_o
);

  localparam int PW = W + 1;

  // One restoring step. The next dividend bit is shifted into the partial
  // remainder, and the divisor is subtracted when it fits. The partial value
  // needs W+1 bits because the running remainder may reach dvsr-1.
  function automatic logic [PW-1:0] trial_sub(input logic [PW-1:0] part,
                                               input logic [W-1:0]  d);
    return part - {1'b0, d};
  endfunction

  logic [PW-1:0] partial;
  logic [PW-1:0] diff;
  logic          fits;

  always_comb begin
    partial = {rem_i, quo_i[W-1]};
    diff    = trial_sub(partial, dvsr_i);
    fits    = (partial >= {1'b0, dvsr_i});
    rem_o   = fits ? diff[W-1:0] : partial[W-1:0];
    qbit_o  = fits;
    quo_o   = {quo_i[W-2:0], fits};
  end

endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ovf_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);
  localparam logic [CW-1:0] ONE   = CW'(1);

  udiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last_step;

  assign accept_o  = start_i && (state_q == UD_IDLE);
  assign step_o    = (state_q == UD_RUN);
  assign last_step = step_o && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UD_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        UD_IDLE: begin
          if (accept_o) begin
            if (ovf_i) begin
              done_q <= 1'b1;
            end else begin
              state_q <= UD_RUN;
              cnt_q   <= STEPS;
            end
          end
        end
        UD_RUN: begin
          cnt_q <= cnt_q - ONE;
          if (last_step) begin
            state_q <= UD_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= UD_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == UD_RUN);
  assign done_o = done_q;

endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dvsr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] dvsr_q;
  logic         ovf_q;

  // Internal events, named so the checker can observe them.
  logic         start_taken;
  logic         step_en;
  logic         ovf_hit;
  logic [W-1:0] rem_next;
  logic [W-1:0] quo_next;
  logic         qbit;

  udiv_ovf_detect #(.W(W)) u_ovf (
    .hi_i   (hi_i),
    .dvsr_i (dvsr_i),
    .ovf_o  (ovf_hit)
  );

  udiv_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ovf_i    (ovf_hit),
    .accept_o (start_taken),
    .step_o   (step_en),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  udiv_step #(.W(W)) u_step (
    .rem_i  (hi_q),
    .quo_i  (lo_q),
    .dvsr_i (dvsr_q),
    .rem_o  (rem_next),
    .quo_o  (quo_next),
    .qbit_o (qbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      dvsr_q <= '0;
      ovf_q  <= 1'b0;
    end else if (start_taken) begin
      dvsr_q <= dvsr_i;
      ovf_q  <= ovf_hit;
      hi_q   <= hi_i;
      lo_q   <= ovf_hit ? ALL_ONES : lo_i;
    end else if (step_en) begin
      hi_q <= rem_next;
      lo_q <= quo_next;
    end
  end

  assign hi_o  = hi_q;
  assign lo_o  = lo_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/udiv_core_chk.sv
module udiv_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] hi_i,
  input logic [W-1:0] dvsr_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic         ovf_o,
  input logic [W-1:0] dvsr_q,
  input logic         start_taken
);

  localparam int CW = $clog2(W + 2);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy_o) run_len <= run_len + CW'(1);
    else run_len <= '0;
  end

  // R2
  a_r2_ovf_decision: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken |=> (ovf_o == ($past(dvsr_i) <= $past(hi_i))));

  // R3
  a_r3_remainder_small: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ovf_o) |-> (hi_o < dvsr_q));

  // R4
  a_r4_ovf_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovf_o) |-> (lo_o == {W{1'b1}}));

  // R5
  a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && !ovf_o && (run_len == CW'(W))));

  // R6
  a_r6_ovf_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_taken && (dvsr_i <= hi_i)) |=> (!busy_o && done_o));

  // R7
  a_r7_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(dvsr_q));

  // R8
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  // R9
  a_r9_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_taken) |=> ($stable(hi_o) && $stable(lo_o) && $stable(ovf_o)));

endmodule

bind udiv_core udiv_core_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .hi_i        (hi_i),
  .dvsr_i      (dvsr_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .hi_o        (hi_o),
  .lo_o        (lo_o),
  .ovf_o       (ovf_o),
  .dvsr_q      (dvsr_q),
  .start_taken (start_taken)
);

// File: tb/udiv_core_bench.sv
module udiv_core_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] hi_i = '0;
  logic [W-1:0] lo_i = '0;
  logic [W-1:0] dvsr_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] hi_o;
  logic [W-1:0] lo_o;
  logic         ovf_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  udiv_core #(.W(W)) u_udiv_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .hi_i    (hi_i),
    .lo_i    (lo_i),
    .dvsr_i  (dvsr_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o),
    .ovf_o   (ovf_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Waits for done, counting negedges after the accepting edge.
  task automatic wait_done(output int n, output bit busy0);
    n = 0;
    busy0 = busy_o;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic verify(input logic [W-1:0] h, l, d, input int n, input bit busy0);
    logic [2*W-1:0] dd;
    bit eo;
    dd = {h, l};
    eo = (d <= h);
    check(ovf_o == eo, "R2 overflow flag", ovf_o, eo);
    if (eo) begin
      check(lo_o == {W{1'b1}}, "R4 quotient all ones", lo_o, {W{1'b1}});
      check(hi_o == h, "R4 high word kept", hi_o, h);
      check(n == 0 && !busy0, "R6 immediate done", n, 0);
    end else begin
      check(lo_o == W'(dd / {{W{1'b0}}, d}), "R3 quotient", lo_o, dd / {{W{1'b0}}, d});
      check(hi_o == W'(dd % {{W{1'b0}}, d}), "R3 remainder", hi_o, dd % {{W{1'b0}}, d});
      check(n == W && busy0, "R5 latency", n, W);
    end
    @(negedge clk);
    check(!done_o, "R8 done one cycle", done_o, 0);
  endtask

  task automatic run_div(input logic [W-1:0] h, l, d);
    int n;
    bit b0;
    @(negedge clk);
    hi_i = h; lo_i = l; dvsr_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n, b0);
    verify(h, l, d, n, b0);
  endtask

  task automatic test_reset();
    check(!busy_o && !done_o && !ovf_o, "R1 reset flags", {busy_o, done_o, ovf_o}, 0);
    check(hi_o == '0 && lo_o == '0, "R1 reset words", {hi_o, lo_o}, 0);
  endtask

  task automatic test_msb_families();
    run_div(16'hF0F0, 16'h0F0F, 16'hF0F0);
    for (int k = 8; k < 16; k++) begin
      logic [3:0] n4;
      n4 = 4'(k);
      run_div({n4, 4'h0, n4, 4'h0}, {4'h0, n4, 4'h0, n4}, {n4, 4'h0, n4, 4'h0});
      run_div({n4, 8'h00, n4}, {4'h0, n4, n4, 4'h0}, {n4, 8'h00, n4});
      run_div({n4, 12'h000}, {12'h000, n4}, {n4, 12'h000});
      run_div({n4, 4'h0, n4, n4}, {4'h0, n4, n4, n4}, {n4, 4'h0, n4, n4});
    end
  endtask

  task automatic test_borders();
    run_div(16'h1234, 16'h5678, 16'h0000);
    run_div(16'h0000, 16'hABCD, 16'h0000);
    run_div(16'h7FFF, 16'hFFFF, 16'h7FFF);
    run_div(16'h7FFF, 16'hFFFF, 16'h8000);
    run_div(16'hFFFE, 16'hFFFF, 16'hFFFF);
    run_div(16'h0000, 16'hFFFF, 16'h0001);
    run_div(16'h0000, 16'h0000, 16'h0003);
  endtask

  task automatic test_restart_ignored();
    int n;
    bit b0;
    @(negedge clk);
    hi_i = 16'h0123; lo_i = 16'h4567; dvsr_i = 16'h89AB; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    b0 = busy_o;
    repeat (3) @(negedge clk);
    hi_i = 16'hFFFF; lo_i = 16'h0000; dvsr_i = 16'h0001; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 4;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    verify(16'h0123, 16'h4567, 16'h89AB, n, b0); // R7
  endtask

  task automatic test_hold();
    logic [W-1:0] h0, l0;
    logic o0;
    run_div(16'h0042, 16'h1357, 16'h00C3);
    h0 = hi_o; l0 = lo_o; o0 = ovf_o;
    dvsr_i = 16'h0001; hi_i = 16'hFFFF;
    repeat (5) @(negedge clk);
    check(hi_o == h0 && lo_o == l0 && ovf_o == o0, "R9 results held", {hi_o, lo_o}, {h0, l0});
    check(!done_o && !busy_o, "R9 idle after done", {done_o, busy_o}, 0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] h, l, d;
      h = W'($urandom);
      l = W'($urandom);
      d = W'($urandom);
      if (i % 2 == 0) h = h >> ($urandom % W);
      run_div(h, l, d);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_msb_families();
    test_borders();
    test_restart_ignored();
    test_hold();
    test_random();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule